// File: doc/BRIEF.md
# QDR Burst-Four Memory Host Controller

This controller connects two simple request interfaces to a quad-data-rate memory that has separate read and write data paths and moves data in bursts of four words. The read interface takes one burst address and later returns all four words in a single response beat. The write interface takes one burst address, four data words and a per-word lane-enable mask. The controller turns these requests into the memory's pin activity. It drives two active-low port selects and one shared address bus. It sends write words with their active-low lane selects out one per clock phase, and it collects the returning read words.

The design runs on one clock whose every rising edge stands for one memory phase. Even phases are K rising edges and odd phases are K# rising edges, so one K period is two controller cycles. A free-running four-phase frame splits the shared address bus into two slots. The read slot is on one K edge and the write slot is on the other. Each port can start at most one burst per frame, and a read burst and a write burst can be in flight in the same frame.

Top module: `qdr_host_ctrl`

## Requirements
- R1: After reset both port selects are high, both request interfaces are ready, and no read response is signalled.
- R2: A port select goes low for exactly one phase to start a burst. The read select is only ever low on frame phase 0, so read selects are a multiple of 4 phases apart. The write select is only ever low on frame phase 2, so a write select falls 2 phases (mod 4) after any read select. The two selects are never low in the same phase.
- R3: While a select is low, the address bus carries the burst address of the request that select belongs to.
- R4: The four words of a write request go out on the data bus in word order 0,1,2,3. Word 0 goes out in the phase where the write select is low, and the next three words follow on the next three phases.
- R5: Lane selects are active low, one per 9-bit lane. Select bit j covers data bits [9j+8:9j]. For word w, bit j goes low exactly when request enable bit w*LANES+j is 1.
- R6: A lane whose enable bit is 0 leaves that memory lane unchanged, which can be seen through a later read of the same address.
- R7: Each request interface accepts one request and then drops ready until that request has been issued on its slot. Each port therefore takes at most one request per four phases.
- R8: The controller samples read word k on the clock edge RD_LAT+1+k edges after the memory samples the read select, for k = 0 to 3. Data the memory drives RD_LAT+k edges after that select is therefore captured. The response is a single one-cycle pulse, with word k in rd_rsp_data[k*DW +: DW].
- R9: A read burst and a write burst can be in progress within the same four-phase frame without disturbing each other.
- R10: Read responses return in the order the read requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock; each rising edge is one memory phase |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request accepted when high with valid |
| rd_req_addr | input | AW | Read burst address |
| rd_rsp_valid | output | 1 | One-cycle pulse marking a complete read burst |
| rd_rsp_data | output | 4*DW | Four read words, word k at [k*DW +: DW] |
| wr_req_valid | input | 1 | Write request present |
| wr_req_ready | output | 1 | Write request accepted when high with valid |
| wr_req_addr | input | AW | Write burst address |
| wr_req_data | input | 4*DW | Four write words, word k at [k*DW +: DW] |
| wr_req_be | input | 4*LANES | Lane enables, bit w*LANES+j for lane j of word w |
| mem_rps_n | output | 1 | Active-low read port select |
| mem_wps_n | output | 1 | Active-low write port select |
| mem_addr | output | AW | Shared, time-sliced burst address bus |
| mem_d | output | DW | Write data, one word per phase |
| mem_bws_n | output | LANES | Active-low lane selects for the current write word |
| mem_q | input | DW | Read data from the memory |

## Verification
The hardest situation to reach is a read burst and a write burst overlapping in one frame, with the read capture window still open while the next select is issued. Idle-then-request stimulus never produces this. To reach it, the bench forks independent read and write drivers within each round. Write and read addresses are kept disjoint inside a round, so every read's expected contents are fixed when the read is accepted. A pin monitor records when the read and write selects fall relative to each other and confirms that a 2-phase overlap actually happened. Partial lane masks on rewritten addresses expose any lane written by mistake.

// File: rtl/qdrc_pkg.sv
`timescale 1ns/1ps
package qdrc_pkg;
  localparam int LANE_BITS = 9;
  localparam int BURST_LEN = 4;

  // Four-phase frame: read slot on one K edge, write slot on the other.
  typedef enum logic [1:0] {
    PH_RD_K  = 2'd0,
    PH_RD_KN = 2'd1,
    PH_WR_K  = 2'd2,
    PH_WR_KN = 2'd3
  } phase_e;

  function automatic phase_e phase_after(phase_e p);
    logic [1:0] nxt;
    nxt = p + 2'd1;
    return phase_e'(nxt);
  endfunction

  function automatic logic opens_read_slot(phase_e p);
    return phase_after(p) == PH_RD_K;
  endfunction

  function automatic logic opens_write_slot(phase_e p);
    return phase_after(p) == PH_WR_K;
  endfunction
endpackage

// File: rtl/qdrc_phase_gen.sv
`timescale 1ns/1ps
module qdrc_phase_gen
  import qdrc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph_o,
  output logic   rd_open_o,
  output logic   wr_open_o
);
  phase_e ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_RD_K;
    else        ph_q <= phase_after(ph_q);
  end

  assign ph_o      = ph_q;
  assign rd_open_o = opens_read_slot(ph_q);
  assign wr_open_o = opens_write_slot(ph_q);

  // R2
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_open_o && wr_open_o));
endmodule

// File: rtl/qdrc_rd_path.sv
`timescale 1ns/1ps
module qdrc_rd_path
  import qdrc_pkg::*;
#(
  parameter int AW      = 18,
  parameter int DW      = 18,
  parameter int CAP_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              slot_open,
  output logic              issue,
  output logic [AW-1:0]     issue_addr,
  input  logic              sel_n_seen,
  input  logic [DW-1:0]     q_in,
  output logic              rsp_valid,
  output logic [4*DW-1:0]   rsp_data
);
  localparam int TRK_W = CAP_DLY + BURST_LEN;

  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic          accept;
  logic [TRK_W-1:0] trk_q;
  logic [BURST_LEN-1:0] cap_hit;
  logic [4*DW-1:0] cap_q;
  logic rsp_q;

  assign req_ready  = !pend_q;
  assign accept     = req_valid && req_ready;
  assign issue      = pend_q && slot_open;
  assign issue_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      addr_q <= req_addr;
    end else if (issue) begin
      pend_q <= 1'b0;
    end
  end

  // Bit j set: the memory sampled a low read select j+1 edges ago.
  always_ff @(posedge clk) begin
    if (!rst_n) trk_q <= '0;
    else        trk_q <= {trk_q[TRK_W-2:0], !sel_n_seen};
  end

  for (genvar k = 0; k < BURST_LEN; k++) begin : g_hit
    assign cap_hit[k] = trk_q[CAP_DLY+k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
      rsp_q <= 1'b0;
    end else begin
      for (int k = 0; k < BURST_LEN; k++) begin
        if (cap_hit[k]) cap_q[k*DW +: DW] <= q_in;
      end
      rsp_q <= cap_hit[BURST_LEN-1];
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_data  = cap_q;

  // R7
  rd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R8
  cap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_hit));
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/qdrc_wr_path.sv
`timescale 1ns/1ps
module qdrc_wr_path
  import qdrc_pkg::*;
#(
  parameter int AW    = 18,
  parameter int LANES = 2,
  localparam int DW   = LANES * LANE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic [4*DW-1:0]      req_data,
  input  logic [4*LANES-1:0]   req_be,
  input  logic                 slot_open,
  output logic                 issue,
  output logic [AW-1:0]        issue_addr,
  output logic [DW-1:0]        d_o,
  output logic [LANES-1:0]     bws_n_o
);
  logic                 pend_q;
  logic [AW-1:0]        addr_q;
  logic [4*DW-1:0]      data_q;
  logic [4*LANES-1:0]   be_q;
  logic                 accept;
  logic [3*DW-1:0]      sh_data;
  logic [3*LANES-1:0]   sh_be;
  logic [1:0]           sh_cnt;

  assign req_ready  = !pend_q;
  assign accept     = req_valid && req_ready;
  assign issue      = pend_q && slot_open;
  assign issue_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      addr_q <= req_addr;
      data_q <= req_data;
      be_q   <= req_be;
    end else if (issue) begin
      pend_q <= 1'b0;
    end
  end

  // Shadow copy frees the request holder on issue so the next request
  // can be taken while the current burst is still being shifted out.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_o     <= '0;
      bws_n_o <= '1;
      sh_data <= '0;
      sh_be   <= '0;
      sh_cnt  <= 2'd0;
    end else if (issue) begin
      d_o     <= data_q[DW-1:0];
      bws_n_o <= ~be_q[LANES-1:0];
      sh_data <= data_q[4*DW-1:DW];
      sh_be   <= be_q[4*LANES-1:LANES];
      sh_cnt  <= 2'd3;
    end else if (sh_cnt != 2'd0) begin
      d_o     <= sh_data[DW-1:0];
      bws_n_o <= ~sh_be[LANES-1:0];
      sh_data <= {{DW{1'b0}}, sh_data[3*DW-1:DW]};
      sh_be   <= {{LANES{1'b0}}, sh_be[3*LANES-1:LANES]};
      sh_cnt  <= sh_cnt - 2'd1;
    end else begin
      bws_n_o <= '1;
    end
  end

  // R7
  wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R4
  ser_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> sh_cnt == 2'd0);
endmodule

// File: rtl/qdr_host_ctrl.sv
`timescale 1ns/1ps
module qdr_host_ctrl
  import qdrc_pkg::*;
#(
  parameter int AW     = 18,
  parameter int LANES  = 2,
  parameter int RD_LAT = 2,
  localparam int DW    = LANES * LANE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req_valid,
  output logic                 rd_req_ready,
  input  logic [AW-1:0]        rd_req_addr,
  output logic                 rd_rsp_valid,
  output logic [4*DW-1:0]      rd_rsp_data,
  input  logic                 wr_req_valid,
  output logic                 wr_req_ready,
  input  logic [AW-1:0]        wr_req_addr,
  input  logic [4*DW-1:0]      wr_req_data,
  input  logic [4*LANES-1:0]   wr_req_be,
  output logic                 mem_rps_n,
  output logic                 mem_wps_n,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_d,
  output logic [LANES-1:0]     mem_bws_n,
  input  logic [DW-1:0]        mem_q
);
  phase_e        cur_ph;
  logic          rd_open, wr_open;
  logic          rd_issue, wr_issue;
  logic [AW-1:0] rd_iaddr, wr_iaddr;

  qdrc_phase_gen u_ph (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph_o      (cur_ph),
    .rd_open_o (rd_open),
    .wr_open_o (wr_open)
  );

  qdrc_rd_path #(.AW(AW), .DW(DW), .CAP_DLY(RD_LAT)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (rd_req_valid),
    .req_ready  (rd_req_ready),
    .req_addr   (rd_req_addr),
    .slot_open  (rd_open),
    .issue      (rd_issue),
    .issue_addr (rd_iaddr),
    .sel_n_seen (mem_rps_n),
    .q_in       (mem_q),
    .rsp_valid  (rd_rsp_valid),
    .rsp_data   (rd_rsp_data)
  );

  qdrc_wr_path #(.AW(AW), .LANES(LANES)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (wr_req_valid),
    .req_ready  (wr_req_ready),
    .req_addr   (wr_req_addr),
    .req_data   (wr_req_data),
    .req_be     (wr_req_be),
    .slot_open  (wr_open),
    .issue      (wr_issue),
    .issue_addr (wr_iaddr),
    .d_o        (mem_d),
    .bws_n_o    (mem_bws_n)
  );

  // Shared address bus: the two slots never open in the same phase.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rps_n <= 1'b1;
      mem_wps_n <= 1'b1;
      mem_addr  <= '0;
    end else begin
      mem_rps_n <= !rd_issue;
      mem_wps_n <= !wr_issue;
      if (rd_issue)      mem_addr <= rd_iaddr;
      else if (wr_issue) mem_addr <= wr_iaddr;
    end
  end

  // R2
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rps_n && !mem_wps_n));
  // R2
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rps_n |=> mem_rps_n);
  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wps_n |=> mem_wps_n);
  // R2
  rd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rps_n |-> cur_ph == PH_RD_K);
  // R2
  wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wps_n |-> cur_ph == PH_WR_K);
  // R3
  rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> mem_addr == $past(rd_iaddr));
endmodule

// File: tb/qdr_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module qdr_host_ctrl_tb_top;
  localparam int AW = 4;
  localparam int LANES = 2;
  localparam int RD_LAT = 3;
  localparam int DW = LANES * 9;
  localparam int NLOC = (1 << AW) * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req_valid = 1'b0, wr_req_valid = 1'b0;
  logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
  logic [4*DW-1:0] wr_req_data = '0;
  logic [4*LANES-1:0] wr_req_be = '0;
  logic rd_req_ready, wr_req_ready, rd_rsp_valid;
  logic [4*DW-1:0] rd_rsp_data;
  logic mem_rps_n, mem_wps_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_d;
  logic [LANES-1:0] mem_bws_n;
  logic [DW-1:0] mem_q = '0;

  int n_checks = 0, n_err = 0;
  logic [DW-1:0] mem_arr [NLOC];
  logic [DW-1:0] exp_arr [NLOC];
  logic [4*DW-1:0] exp_q [$];

  always #10 clk = ~clk;

  qdr_host_ctrl #(.AW(AW), .LANES(LANES), .RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
    .wr_req_data(wr_req_data), .wr_req_be(wr_req_be),
    .mem_rps_n(mem_rps_n), .mem_wps_n(mem_wps_n), .mem_addr(mem_addr),
    .mem_d(mem_d), .mem_bws_n(mem_bws_n), .mem_q(mem_q));

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: write words on consecutive phases, read data RD_LAT edges after select.
  int cyc = 0, widx = 0, last_rps = -1, last_wps = -1;
  logic [AW-1:0] wbase;
  int rs_start [$];
  logic [AW-1:0] rs_addr [$];
  bit conc_seen = 0;

  task automatic mem_store(input int loc);
    for (int j = 0; j < LANES; j++)
      if (!mem_bws_n[j]) mem_arr[loc][9*j +: 9] = mem_d[9*j +: 9];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      widx = 0; cyc = 0; last_rps = -1; last_wps = -1;
      rs_start.delete(); rs_addr.delete();
    end else begin
      cyc++;
      if (rs_start.size() > 0) begin
        int k;
        k = cyc - rs_start[0] - RD_LAT;
        if (k >= 0 && k < 4) begin
          mem_q <= mem_arr[int'(rs_addr[0]) * 4 + k];
          if (k == 3) begin
            void'(rs_start.pop_front());
            void'(rs_addr.pop_front());
          end
        end
      end
      if (!mem_rps_n && !mem_wps_n) check(0, "R2 both selects low", 2'b00, 2'b11);
      if (!mem_rps_n) begin
        rs_start.push_back(cyc);
        rs_addr.push_back(mem_addr);
        if (last_rps >= 0)
          check(((cyc - last_rps) % 4 == 0) && (cyc - last_rps >= 4),
                "R2 read slot spacing", cyc - last_rps, 4);
        if (last_wps >= 0 && cyc - last_wps == 2) conc_seen = 1;
        last_rps = cyc;
      end
      if (!mem_wps_n) begin
        wbase = mem_addr;
        mem_store(int'(wbase) * 4);
        widx = 1;
        if (last_rps >= 0)
          check((cyc - last_rps) % 4 == 2, "R2 write slot offset",
                (cyc - last_rps) % 4, 2);
        if (last_rps >= 0 && cyc - last_rps == 2) conc_seen = 1;
        last_wps = cyc;
      end else if (widx > 0) begin
        mem_store(int'(wbase) * 4 + widx);
        widx = (widx == 3) ? 0 : widx + 1;
      end
    end
  end

  // Scoreboard monitor: R8 capture, R10 ordering, R3..R6 via contents.
  always @(negedge clk) begin
    if (rst_n && rd_rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R10 unexpected response", rd_rsp_data, 0);
      else begin
        logic [4*DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_rsp_data == e, "R8/R10 read burst contents", rd_rsp_data, e);
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [4*DW-1:0] d,
                          input logic [4*LANES-1:0] be);
    @(negedge clk);
    wr_req_valid = 1; wr_req_addr = a; wr_req_data = d; wr_req_be = be;
    while (!wr_req_ready) @(negedge clk);
    @(posedge clk);
    for (int w = 0; w < 4; w++)
      for (int j = 0; j < LANES; j++)
        if (be[w*LANES+j]) exp_arr[int'(a)*4+w][9*j +: 9] = d[w*DW + 9*j +: 9];
    @(negedge clk);
    wr_req_valid = 0;
    check(wr_req_ready == 0, "R7 write ready drops after accept", wr_req_ready, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    logic [4*DW-1:0] e;
    @(negedge clk);
    rd_req_valid = 1; rd_req_addr = a;
    while (!rd_req_ready) @(negedge clk);
    @(posedge clk);
    for (int w = 0; w < 4; w++) e[w*DW +: DW] = exp_arr[int'(a)*4+w];
    exp_q.push_back(e);
    @(negedge clk);
    rd_req_valid = 0;
    check(rd_req_ready == 0, "R7 read ready drops after accept", rd_req_ready, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (12) @(posedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog R8 responses stalled", exp_q.size(), 0);
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < NLOC; i++) begin
      mem_arr[i] = DW'(i * 37 + 11);
      exp_arr[i] = DW'(i * 37 + 11);
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R1
    check(mem_rps_n && mem_wps_n, "R1 selects idle", {mem_rps_n, mem_wps_n}, 2'b11);
    check(rd_req_ready && wr_req_ready, "R1 ready", {rd_req_ready, wr_req_ready}, 2'b11);
    check(!rd_rsp_valid, "R1 no response", rd_rsp_valid, 0);

    // R3 R4: full write then readback; R6 R5: partial lanes then readback
    do_read(4'd3);
    do_write(4'd5, {18'h3ffff, 18'h2aaaa, 18'h15555, 18'h00f0f}, 8'hff);
    drain();
    do_read(4'd5);
    drain();
    do_write(4'd5, {18'h01234, 18'h0abcd, 18'h3c3c3, 18'h12121}, 8'b01_10_00_11);
    drain();
    do_read(4'd5);
    drain();
    do_write(4'd9, {4{18'h0}}, 8'h00);
    drain();
    do_read(4'd9);
    drain();

    // R9 R10: concurrent streams, disjoint addresses within a round
    for (int r = 0; r < 40; r++) begin
      logic [AW-1:0] wa [3];
      logic [AW-1:0] ra [3];
      for (int i = 0; i < 3; i++) begin
        bit dup;
        do begin
          wa[i] = AW'($urandom);
          dup = 0;
          for (int j = 0; j < i; j++) if (wa[j] == wa[i]) dup = 1;
        end while (dup);
      end
      for (int i = 0; i < 3; i++) begin
        bit hit;
        do begin
          ra[i] = AW'($urandom);
          hit = 0;
          for (int j = 0; j < 3; j++) if (wa[j] == ra[i]) hit = 1;
        end while (hit);
      end
      fork
        begin
          for (int i = 0; i < 3; i++) begin
            logic [127:0] rd;
            rd = {$urandom, $urandom, $urandom, $urandom};
            do_write(wa[i], rd[4*DW-1:0], 8'($urandom));
          end
        end
        begin
          for (int i = 0; i < 3; i++) do_read(ra[i]);
        end
      join
      drain();
    end
    for (int i = 0; i < 16; i++) do_read(AW'(i));
    drain();
    check(conc_seen, "R9 read and write overlapped in one frame", conc_seen, 1);
    report();
    $finish;
  end
endmodule